// File: doc/BRIEF.md
# Key-Guarded Byte-Port Watchdog Timer

This block is a watchdog timer whose configuration sits behind a pair of byte-wide host ports. One port is the index port and the other is the data port. The index port chooses a configuration register, and the data port reads or writes that register. Software cannot change any setting until it opens the block. To open it, software writes the key code 0x87 to the index port twice in a row. It then selects the watchdog page by writing index 0x07 and data 0x08. Writing 0xAA to the index port closes the block again.

Once the block is open and the watchdog page is selected, software can do four things:
- choose whether the countdown steps on a seconds tick or a minutes tick;
- load an 8-bit countdown value;
- allow keyboard or mouse interrupt pulses to reload that value;
- enable the timer.

The two tick enables come from outside the block. When an enabled count steps from 1 to 0, the block drives a reset request for a fixed number of clocks. At the end of that request it clears its own enable bit.

Top module: `idx_wdog`

## Requirements
- R1: After reset the block is closed, the timer is disabled, `wdt_reset` is 0, and reads of both the index port (0x2E) and the data port (0x2F) return 0xFF.
- R2: Two back-to-back writes of 0x87 to the index port open the block. In the open state, an index-port read returns the current index, which is 0x00 right after opening. Writing index 0x07 and then data 0x08 selects the watchdog page, and register 0x07 reads back the page number.
- R3: Any other value written to the index port between the two 0x87 writes restarts the key sequence, so the block stays closed and the index port still reads 0xFF.
- R4: While the block is closed, or while the selected page is not 0x08, writes to the data port change no watchdog register, and data-port reads of the watchdog registers return 0xFF.
- R5: Writing 0xAA to the index port closes the block and clears both the index and the page, so the full key and page sequence is needed again.
- R6: Bit 0 of register 0x30 enables the timer. The register reads back as {7'b0, enable}.
- R7: Bit 3 of register 0xF5 picks the unit: 0 counts on `tick_sec` and 1 counts on `tick_min`. The other tick input has no effect. The register reads back as {4'b0, unit, 3'b0}.
- R8: A write to register 0xF6 loads both the live count and the reload value. A read of 0xF6 returns the live count. Apart from loads and reloads, the count never increases.
- R9: When bit 6 of register 0xF7 is set, a `kbd_irq` pulse reloads the count. When bit 7 is set, a `mouse_irq` pulse reloads it. When a bit is clear, its pulse has no effect. The register reads back as {mouse, kbd, 6'b0}.
- R10: When an enabled count steps from 1 to 0, `wdt_reset` goes high for PULSE_LEN clocks (4 by default). The enable bit is then clear.
- R11: While the timer is disabled, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe for one host byte write |
| io_addr | input | 8 | Host port address (0x2E index, 0x2F data) |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the addressed port |
| tick_sec | input | 1 | One-clock seconds tick enable |
| tick_min | input | 1 | One-clock minutes tick enable |
| kbd_irq | input | 1 | Keyboard interrupt event pulse |
| mouse_irq | input | 1 | Mouse interrupt event pulse |
| wdt_reset | output | 1 | Reset request on expiry |

## Verification
The access guard is driven by a random mix of index values. The mix is weighted toward the key, lock and page codes, and each write is followed by reads of both ports. These runs separate a correct key sequence from one that was interrupted, a page that was selected from one that was not, and a data write that was accepted from one that was dropped. Directed cases then pulse one tick input at a time under each unit setting, to show which tick the count follows. They send keyboard and mouse pulses with each reload bit set and with it clear. Finally they step the count from 1 to 0 to check the length of the reset request and the clearing of the enable bit.

// File: rtl/idx_wdog_pkg.sv
package idx_wdog_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_CODE   = 8'h87;
  localparam logic [7:0] LOCK_CODE  = 8'hAA;
  localparam logic [7:0] PAGE_IDX   = 8'h07;
  localparam logic [7:0] WDG_PAGE   = 8'h08;
  localparam logic [7:0] IDX_ENABLE = 8'h30;
  localparam logic [7:0] IDX_UNIT   = 8'hF5;
  localparam logic [7:0] IDX_COUNT  = 8'hF6;
  localparam logic [7:0] IDX_RELOAD = 8'hF7;

endpackage

// File: rtl/idx_wdog_gate.sv
module idx_wdog_gate
  import idx_wdog_pkg::*;
#(
  parameter logic [7:0] INDEX_ADDR = 8'h2E,
  parameter logic [7:0] DATA_ADDR  = 8'h2F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       grant_o,
  output logic [7:0] idx_o,
  output logic [7:0] page_o
);

  key_state_e state_q, state_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] page_q, page_d;
  logic       idx_wr, dat_wr;

  assign idx_wr = wr_i && (addr_i == INDEX_ADDR);
  assign dat_wr = wr_i && (addr_i == DATA_ADDR);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    page_d  = page_q;
    if (idx_wr) begin
      case (state_q)
        KEY_IDLE: if (wdata_i == KEY_CODE) state_d = KEY_HALF;
        KEY_HALF: state_d = (wdata_i == KEY_CODE) ? KEY_OPEN : KEY_IDLE;
        KEY_OPEN: begin
          if (wdata_i == LOCK_CODE) begin
            state_d = KEY_IDLE;
            idx_d   = 8'h00;
            page_d  = 8'h00;
          end else begin
            idx_d = wdata_i;
          end
        end
        default: state_d = KEY_IDLE;
      endcase
    end
    if (dat_wr && (state_q == KEY_OPEN) && (idx_q == PAGE_IDX)) begin
      page_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
      idx_q   <= 8'h00;
      page_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      page_q  <= page_d;
    end
  end

  assign open_o  = (state_q == KEY_OPEN);
  assign grant_o = open_o && (page_q == WDG_PAGE);
  assign idx_o   = idx_q;
  assign page_o  = page_q;

  // R5
  lock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata_i == LOCK_CODE) |=> (state_q == KEY_IDLE && page_q == 8'h00));

  // R3
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && state_q == KEY_HALF && wdata_i != KEY_CODE) |=> (state_q == KEY_IDLE));

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> ($past(state_q) == KEY_HALF));

endmodule

// File: rtl/idx_wdog_cfg.sv
module idx_wdog_cfg
  import idx_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       is_data_i,
  input  logic       open_i,
  input  logic       grant_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] page_i,
  input  logic [7:0] wdata_i,
  input  logic       en_clr_i,
  input  logic [7:0] cnt_i,
  output logic       en_o,
  output logic       unit_o,
  output logic [7:0] reload_o,
  output logic       kbd_en_o,
  output logic       mouse_en_o,
  output logic       cnt_ld_o,
  output logic [7:0] rdata_o
);

  logic       en_q, en_d;
  logic       unit_q, unit_d;
  logic [7:0] reload_q, reload_d;
  logic       kbd_q, kbd_d;
  logic       mouse_q, mouse_d;
  logic       cfg_wr;

  assign cfg_wr = wr_i && is_data_i && grant_i;

  always_comb begin
    en_d     = en_q;
    unit_d   = unit_q;
    reload_d = reload_q;
    kbd_d    = kbd_q;
    mouse_d  = mouse_q;
    if (cfg_wr) begin
      case (idx_i)
        IDX_ENABLE: en_d = wdata_i[0];
        IDX_UNIT:   unit_d = wdata_i[3];
        IDX_COUNT:  reload_d = wdata_i;
        IDX_RELOAD: begin
          kbd_d   = wdata_i[6];
          mouse_d = wdata_i[7];
        end
        default: ;
      endcase
    end
    if (en_clr_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      unit_q   <= 1'b0;
      reload_q <= 8'h00;
      kbd_q    <= 1'b0;
      mouse_q  <= 1'b0;
    end else begin
      en_q     <= en_d;
      unit_q   <= unit_d;
      reload_q <= reload_d;
      kbd_q    <= kbd_d;
      mouse_q  <= mouse_d;
    end
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (open_i) begin
      if (idx_i == PAGE_IDX) begin
        rdata_o = page_i;
      end else if (grant_i) begin
        case (idx_i)
          IDX_ENABLE: rdata_o = {7'b0, en_q};
          IDX_UNIT:   rdata_o = {4'b0, unit_q, 3'b0};
          IDX_COUNT:  rdata_o = cnt_i;
          IDX_RELOAD: rdata_o = {mouse_q, kbd_q, 6'b0};
          default:    rdata_o = 8'h00;
        endcase
      end
    end
  end

  assign en_o       = en_q;
  assign unit_o     = unit_q;
  assign reload_o   = reload_q;
  assign kbd_en_o   = kbd_q;
  assign mouse_en_o = mouse_q;
  assign cnt_ld_o   = cfg_wr && (idx_i == IDX_COUNT);

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |=> ($stable(unit_q) && $stable(reload_q) && $stable(kbd_q) && $stable(mouse_q)));

  // R6
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(grant_i && wr_i && is_data_i));

endmodule

// File: rtl/idx_wdog_count.sv
module idx_wdog_count #(
  parameter int PULSE_LEN = 4,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       unit_i,
  input  logic       tick_sec_i,
  input  logic       tick_min_i,
  input  logic       kbd_irq_i,
  input  logic       mouse_irq_i,
  input  logic       kbd_en_i,
  input  logic       mouse_en_i,
  input  logic [7:0] reload_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] cnt_o,
  output logic       fire_o,
  output logic       en_clr_o
);

  logic [7:0]    cnt_q, cnt_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          tick, reload_evt, expire;

  assign tick       = en_i && (unit_i ? tick_min_i : tick_sec_i);
  assign reload_evt = (kbd_en_i && kbd_irq_i) || (mouse_en_i && mouse_irq_i);
  assign expire     = !ld_i && !reload_evt && tick && (cnt_q == 8'd1);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (reload_evt) begin
      cnt_d = reload_i;
    end else if (tick && cnt_q != 8'd0) begin
      cnt_d = cnt_q - 8'd1;
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if (expire) begin
      pulse_d = PW'(PULSE_LEN);
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 8'h00;
      pulse_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign fire_o   = (pulse_q != '0);
  assign en_clr_o = (pulse_q == PW'(1));

  // R10
  fire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_o) |-> ($past(cnt_q) == 8'd1 && $past(en_i)));

  // R10
  fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fire_o) |-> !en_i);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !reload_evt && !en_i) |=> $stable(cnt_q));

  // R8
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !reload_evt) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/idx_wdog.sv
module idx_wdog
  import idx_wdog_pkg::*;
#(
  parameter logic [7:0] INDEX_ADDR = 8'h2E,
  parameter logic [7:0] DATA_ADDR  = 8'h2F,
  parameter int         PULSE_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       tick_sec,
  input  logic       tick_min,
  input  logic       kbd_irq,
  input  logic       mouse_irq,
  output logic       wdt_reset
);

  logic       open, grant;
  logic [7:0] idx, page;
  logic       en, unit, kbd_en, mouse_en, cnt_ld, en_clr;
  logic [7:0] reload_val, cnt, data_rd;
  logic       is_data;

  assign is_data = (io_addr == DATA_ADDR);

  idx_wdog_gate #(.INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (io_wr),
    .addr_i  (io_addr),
    .wdata_i (io_wdata),
    .open_o  (open),
    .grant_o (grant),
    .idx_o   (idx),
    .page_o  (page)
  );

  idx_wdog_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (io_wr),
    .is_data_i  (is_data),
    .open_i     (open),
    .grant_i    (grant),
    .idx_i      (idx),
    .page_i     (page),
    .wdata_i    (io_wdata),
    .en_clr_i   (en_clr),
    .cnt_i      (cnt),
    .en_o       (en),
    .unit_o     (unit),
    .reload_o   (reload_val),
    .kbd_en_o   (kbd_en),
    .mouse_en_o (mouse_en),
    .cnt_ld_o   (cnt_ld),
    .rdata_o    (data_rd)
  );

  idx_wdog_count #(.PULSE_LEN(PULSE_LEN)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .unit_i      (unit),
    .tick_sec_i  (tick_sec),
    .tick_min_i  (tick_min),
    .kbd_irq_i   (kbd_irq),
    .mouse_irq_i (mouse_irq),
    .kbd_en_i    (kbd_en),
    .mouse_en_i  (mouse_en),
    .reload_i    (reload_val),
    .ld_i        (cnt_ld),
    .ld_val_i    (io_wdata),
    .cnt_o       (cnt),
    .fire_o      (wdt_reset),
    .en_clr_o    (en_clr)
  );

  always_comb begin
    if (io_addr == INDEX_ADDR) io_rdata = open ? idx : 8'hFF;
    else if (is_data)          io_rdata = data_rd;
    else                       io_rdata = 8'hFF;
  end

  // R1
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && io_addr == INDEX_ADDR) |-> (io_rdata == 8'hFF));

endmodule

// File: tb/sim_idx_wdog.sv
module sim_idx_wdog;

  localparam logic [7:0] IA = 8'h2E;
  localparam logic [7:0] DA = 8'h2F;
  localparam int         PL = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_wr;
  logic [7:0] io_addr, io_wdata, io_rdata;
  logic       tick_sec, tick_min, kbd_irq, mouse_irq, wdt_reset;

  int checks = 0;
  int fails  = 0;

  int         m_state;
  logic [7:0] m_idx, m_page, m_cnt, m_rel;
  logic       m_en, m_unit, m_kb, m_ms;

  always #5 clk = ~clk;

  idx_wdog #(.INDEX_ADDR(IA), .DATA_ADDR(DA), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tick_sec(tick_sec),
    .tick_min(tick_min), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
    .wdt_reset(wdt_reset)
  );

  function automatic logic [7:0] model_read(logic [7:0] a);
    if (a == IA) return (m_state == 2) ? m_idx : 8'hFF;
    if (a != DA || m_state != 2) return 8'hFF;
    if (m_idx == 8'h07) return m_page;
    if (m_page != 8'h08) return 8'hFF;
    case (m_idx)
      8'h30:   return {7'b0, m_en};
      8'hF5:   return {4'b0, m_unit, 3'b0};
      8'hF6:   return m_cnt;
      8'hF7:   return {m_ms, m_kb, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    if (a == IA) begin
      if (m_state == 0) begin
        if (d == 8'h87) m_state = 1;
      end else if (m_state == 1) begin
        m_state = (d == 8'h87) ? 2 : 0;
      end else if (d == 8'hAA) begin
        m_state = 0; m_idx = 8'h00; m_page = 8'h00;
      end else begin
        m_idx = d;
      end
    end else if (a == DA && m_state == 2) begin
      if (m_idx == 8'h07) m_page = d;
      else if (m_page == 8'h08) begin
        case (m_idx)
          8'h30: m_en = d[0];
          8'hF5: m_unit = d[3];
          8'hF6: begin m_cnt = d; m_rel = d; end
          8'hF7: begin m_kb = d[6]; m_ms = d[7]; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    io_addr = a;
    #1;
    chk(req, io_rdata, model_read(a));
  endtask

  task automatic reg_wr(logic [7:0] i, logic [7:0] d);
    wr(IA, i);
    wr(DA, d);
  endtask

  task automatic reg_expect(string req, logic [7:0] i, logic [7:0] exp);
    wr(IA, i);
    io_addr = DA;
    #1;
    chk(req, io_rdata, exp);
    chk(req, io_rdata, model_read(DA));
  endtask

  // which: 0 sec, 1 min, 2 kbd, 3 mouse
  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: tick_sec = 1'b1;
      1: tick_min = 1'b1;
      2: kbd_irq = 1'b1;
      default: mouse_irq = 1'b1;
    endcase
    @(negedge clk);
    tick_sec = 1'b0; tick_min = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0;
    if (which == 2 && m_kb) m_cnt = m_rel;
    else if (which == 3 && m_ms) m_cnt = m_rel;
    else if (which < 2 && m_en && (m_unit == (which == 1)) && m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    tick_sec = 1'b0; tick_min = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0;
    m_state = 0; m_idx = 0; m_page = 0; m_cnt = 0; m_rel = 0;
    m_en = 0; m_unit = 0; m_kb = 0; m_ms = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1", IA);
    rd_chk("R1", DA);
    chk("R1", {7'b0, wdt_reset}, 8'h00);

    // R3 interrupted key
    wr(IA, 8'h87); wr(IA, 8'h30); wr(IA, 8'h87);
    io_addr = IA; #1; chk("R3", io_rdata, 8'hFF);
    // R2 second key opens, index 0
    wr(IA, 8'h87);
    io_addr = IA; #1; chk("R2", io_rdata, 8'h00);

    // R4 wrong page
    reg_wr(8'h07, 8'h09);
    reg_expect("R2", 8'h07, 8'h09);
    reg_wr(8'hF6, 8'h55);
    reg_expect("R4", 8'hF6, 8'hFF);
    reg_wr(8'h07, 8'h08);
    reg_expect("R4", 8'hF6, 8'h00);

    // R8, R6, R7 register access
    reg_wr(8'hF6, 8'h03);
    reg_expect("R8", 8'hF6, 8'h03);
    reg_wr(8'h30, 8'hFF);
    reg_expect("R6", 8'h30, 8'h01);
    reg_wr(8'hF5, 8'hFF);
    reg_expect("R7", 8'hF5, 8'h08);

    // R7 minute unit ignores seconds tick
    wr(IA, 8'hF6);
    pulse(0); pulse(0);
    rd_chk("R7", DA); chk("R7", io_rdata, 8'h03);
    pulse(1);
    rd_chk("R7", DA); chk("R7", io_rdata, 8'h02);
    reg_wr(8'hF5, 8'h00);
    wr(IA, 8'hF6);
    pulse(1);
    rd_chk("R7", DA); chk("R7", io_rdata, 8'h02);
    pulse(0);
    rd_chk("R7", DA); chk("R7", io_rdata, 8'h01);

    // R10 expiry pulse
    chk("R10", {7'b0, wdt_reset}, 8'h00);
    pulse(0);
    for (int k = 0; k < PL + 2; k++) begin
      chk("R10", {7'b0, wdt_reset}, (k < PL) ? 8'h01 : 8'h00);
      @(negedge clk);
    end
    m_en = 1'b0;
    reg_expect("R10", 8'h30, 8'h00);
    reg_expect("R10", 8'hF6, 8'h00);

    // R11 disabled timer holds
    reg_wr(8'hF6, 8'h05);
    wr(IA, 8'hF6);
    pulse(0); pulse(0); pulse(1);
    rd_chk("R11", DA); chk("R11", io_rdata, 8'h05);

    // R9 reload sources
    reg_wr(8'hF7, 8'h40);
    reg_expect("R9", 8'hF7, 8'h40);
    reg_wr(8'h30, 8'h01);
    wr(IA, 8'hF6);
    pulse(0);
    rd_chk("R9", DA); chk("R9", io_rdata, 8'h04);
    pulse(3);
    rd_chk("R9", DA); chk("R9", io_rdata, 8'h04);
    pulse(2);
    rd_chk("R9", DA); chk("R9", io_rdata, 8'h05);
    reg_wr(8'hF7, 8'h80);
    wr(IA, 8'hF6);
    pulse(0);
    pulse(2);
    rd_chk("R9", DA); chk("R9", io_rdata, 8'h04);
    pulse(3);
    rd_chk("R9", DA); chk("R9", io_rdata, 8'h05);
    reg_wr(8'h30, 8'h00);
    reg_wr(8'hF7, 8'h00);

    // R5 lock code
    wr(IA, 8'hAA);
    rd_chk("R5", IA); chk("R5", io_rdata, 8'hFF);
    rd_chk("R5", DA);
    wr(IA, 8'h87); wr(IA, 8'h87);
    reg_expect("R5", 8'hF6, 8'hFF);

    // R2 R3 R4 R5 random access sequences
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom % 3;
      if (op < 2) begin
        case ($urandom % 9)
          0, 1: v = 8'h87;
          2: v = 8'hAA;
          3: v = 8'h07;
          4: v = 8'h30;
          5: v = 8'hF5;
          6: v = 8'hF6;
          7: v = 8'hF7;
          default: v = 8'($urandom);
        endcase
        wr(IA, v);
      end else begin
        v = (m_idx == 8'h07 && ($urandom % 3 != 0)) ? 8'h08 : 8'($urandom);
        wr(DA, v);
      end
      rd_chk("R4", IA);
      rd_chk("R4", DA);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule